// File: doc/BRIEF.md
# EPP Host Bus Controller

This block is the host side of a byte-wide enhanced-parallel-port link. A system-side request selects one of three bus cycles: an address write, a data write or a data read. The request also carries the byte to send. The controller then sequences chip select, the direction line, the two strobes and the bus drive enable. Every setup, strobe and hold interval is a clock-cycle count set by a parameter.

Address writes use the address strobe with fixed timing. Data cycles use the data strobe and follow the peripheral's wait line. The strobe is released only once the wait line reads high and the minimum width has passed. The cycle ends only once the wait line reads low again. If the wait line does not respond within a set number of cycles, the cycle is abandoned and an error pulse is raised. The wait line is brought into the clock domain through a chain of flip-flops before the sequencer uses it. Read data is captured from the bus on the edge that releases the data strobe.

Top module: `epp_host_ctrl`

## Requirements
- R1: While reset is held and directly after it, chip select, both strobes and the direction line sit high. Bus drive is off, req_ready is 1, and done_o and err_o are 0.
- R2: An address write (req_kind 0) keeps chip select low, drives the byte and holds the direction line low. This lasts SETUP_CYC cycles before the address strobe falls. The address strobe then stays low for exactly ASTRB_CYC cycles. Byte and chip select stay for AHOLD_CYC cycles after it rises, and the data strobe never falls.
- R3: A data write (req_kind 1) drives the byte and sets the direction line low for SETUP_CYC cycles before the data strobe falls. Neither changes while the strobe is low or during the hold phase.
- R4: The data strobe rises only after the synchronized wait line has been high on a clock edge. It is never shorter than DSTRB_MIN_CYC cycles.
- R5: After the data strobe rises, the cycle ends with a one-cycle done_o pulse. This happens only once HOLD_CYC cycles have passed and the synchronized wait line reads low. req_ready is 1 only between cycles.
- R6: If the wait line has not risen within TIMEOUT_CYC cycles of strobe low, a one-cycle err_o pulse is raised instead of done_o. The same applies if it has not fallen within TIMEOUT_CYC cycles of the hold phase. All bus lines then return to idle.
- R7: A data read (req_kind 2) keeps the direction line high and bus drive off. The data strobe lasts at least the larger of DSTRB_MIN_CYC and RD_DLY_CYC. rd_data_o holds the bus byte sampled on the edge that releases the strobe.
- R8: The wait line passes through SYNC_STAGES flip-flops. With two stages, a wait-line rise that arrives after the minimum width has passed releases the strobe three clock cycles later.
- R9: Requests made while a cycle is in progress are ignored. So is req_kind 3 at any time: chip select stays high and no strobe moves.
- R10: Chip select is low whenever the data strobe is low, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_kind | input | 2 | 0 address write, 1 data write, 2 data read, 3 ignored |
| req_byte | input | DW | Byte to write |
| req_ready | output | 1 | High while no cycle is in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| err_o | output | 1 | One-cycle pulse on wait-line timeout |
| rd_data_o | output | DW | Last byte captured by a data read |
| ncs_o | output | 1 | Chip select, active low |
| nastrb_o | output | 1 | Address strobe, active low |
| ndstrb_o | output | 1 | Data strobe, active low |
| nwrite_o | output | 1 | Direction, low for writes |
| nwait_i | input | 1 | Peripheral wait handshake, asynchronous |
| bus_out_o | output | DW | Byte driven onto the bus |
| bus_oe_o | output | 1 | Bus drive enable |
| bus_in_i | input | DW | Byte read from the bus |

## Verification
The bench builds the block with these values: SETUP_CYC 2, ASTRB_CYC 3, AHOLD_CYC 2, DSTRB_MIN_CYC 4, RD_DLY_CYC 6, HOLD_CYC 2, TIMEOUT_CYC 20 and two synchronizer stages. With these values, reads stretch the strobe beyond the write minimum. A fast peripheral lets the minimum width decide when the strobe is released, and a slow one lets the wait line decide. The short timeout lets a stuck-low and a stuck-high wait line both finish within a few dozen cycles.

// File: rtl/epp_pkg.sv
package epp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_ASTRB = 3'd2,
      ST_AHOLD = 3'd3,
      ST_DSTRB = 3'd4,
      ST_DHOLD = 3'd5
   } epp_state_t;

   typedef enum logic [1:0] {
      KIND_ADDR  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_READ  = 2'd2,
      KIND_RSVD  = 2'd3
   } epp_kind_t;
endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/epp_elapsed_ctr.sv
module epp_elapsed_ctr #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr)             cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl
   import epp_pkg::*;
#(
   parameter int unsigned DW            = 8,
   parameter int unsigned SETUP_CYC     = 2,
   parameter int unsigned ASTRB_CYC     = 3,
   parameter int unsigned AHOLD_CYC     = 2,
   parameter int unsigned DSTRB_MIN_CYC = 7,
   parameter int unsigned RD_DLY_CYC    = 7,
   parameter int unsigned HOLD_CYC      = 2,
   parameter int unsigned TIMEOUT_CYC   = 64,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_kind,
   input  logic [DW-1:0] req_byte,
   output logic          req_ready,
   output logic          done_o,
   output logic          err_o,
   output logic [DW-1:0] rd_data_o,
   output logic          ncs_o,
   output logic          nastrb_o,
   output logic          ndstrb_o,
   output logic          nwrite_o,
   input  logic          nwait_i,
   output logic [DW-1:0] bus_out_o,
   output logic          bus_oe_o,
   input  logic [DW-1:0] bus_in_i
);
   localparam int unsigned CW     = $clog2(TIMEOUT_CYC + 1);
   localparam int unsigned REL_RD = (DSTRB_MIN_CYC > RD_DLY_CYC) ? DSTRB_MIN_CYC : RD_DLY_CYC;

   initial begin
      assert (DW >= 1) else $error("DW must be at least 1");
      assert (SETUP_CYC >= 1 && ASTRB_CYC >= 1 && AHOLD_CYC >= 1)
         else $error("address timing counts must be at least 1");
      assert (DSTRB_MIN_CYC >= 1 && RD_DLY_CYC >= 1 && HOLD_CYC >= 1)
         else $error("data timing counts must be at least 1");
      assert (TIMEOUT_CYC > REL_RD && TIMEOUT_CYC > HOLD_CYC)
         else $error("timeout must exceed strobe and hold counts");
      assert (SETUP_CYC <= TIMEOUT_CYC && ASTRB_CYC <= TIMEOUT_CYC && AHOLD_CYC <= TIMEOUT_CYC)
         else $error("address timing must fit the counter");
      assert (SYNC_STAGES >= 2) else $error("at least two synchronizer stages");
   end

   epp_state_t    st_q, st_d;
   epp_kind_t     kind_q;
   logic [DW-1:0] byte_q, rd_q;
   logic          done_q, err_q, done_d, err_d;
   logic          wait_s;
   logic [CW-1:0] cnt;
   logic          accept, is_rd, is_adr, rel, capture;
   logic [CW-1:0] rel_lim;

   epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (nwait_i),
      .sync_o  (wait_s)
   );

   epp_elapsed_ctr #(.CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_d != st_q),
      .cnt_o (cnt)
   );

   assign is_rd   = (kind_q == KIND_READ);
   assign is_adr  = (kind_q == KIND_ADDR);
   assign accept  = (st_q == ST_IDLE) && req_valid && (req_kind != KIND_RSVD);
   assign rel_lim = is_rd ? CW'(REL_RD - 1) : CW'(DSTRB_MIN_CYC - 1);
   assign rel     = wait_s && (cnt >= rel_lim);
   assign capture = (st_q == ST_DSTRB) && rel && is_rd;

   always_comb begin
      st_d   = st_q;
      done_d = 1'b0;
      err_d  = 1'b0;
      case (st_q)
         ST_IDLE:  if (accept) st_d = ST_SETUP;
         ST_SETUP: if (cnt == CW'(SETUP_CYC - 1)) st_d = is_adr ? ST_ASTRB : ST_DSTRB;
         ST_ASTRB: if (cnt == CW'(ASTRB_CYC - 1)) st_d = ST_AHOLD;
         ST_AHOLD: if (cnt == CW'(AHOLD_CYC - 1)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
         end
         ST_DSTRB: begin
            if (rel) st_d = ST_DHOLD;
            else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end
         ST_DHOLD: begin
            if (cnt >= CW'(HOLD_CYC - 1) && !wait_s) begin
               st_d   = ST_IDLE;
               done_d = 1'b1;
            end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= KIND_ADDR;
         byte_q <= '0;
         rd_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= done_d;
         err_q  <= err_d;
         if (accept) begin
            kind_q <= epp_kind_t'(req_kind);
            byte_q <= req_byte;
         end
         if (capture) rd_q <= bus_in_i;
      end
   end

   always_comb begin
      ncs_o    = (st_q == ST_IDLE);
      nastrb_o = (st_q != ST_ASTRB);
      ndstrb_o = (st_q != ST_DSTRB);
      nwrite_o = (st_q == ST_IDLE) ? 1'b1 : is_rd;
      bus_oe_o = (st_q != ST_IDLE) && !is_rd;
   end

   assign bus_out_o = bus_oe_o ? byte_q : '0;
   assign req_ready = (st_q == ST_IDLE);
   assign done_o    = done_q;
   assign err_o     = err_q;
   assign rd_data_o = rd_q;

   AST_DSTRB_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !ndstrb_o |-> !ncs_o); // R10
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ndstrb_o && !nastrb_o)); // R10
   AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ndstrb_o) |-> ($past(wait_s) || err_o)); // R4
   AST_DIR_SET_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ndstrb_o) |-> ($stable(nwrite_o) && $stable(bus_oe_o))); // R3
   AST_DIR_STABLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ndstrb_o && $past(!ndstrb_o)) |-> $stable(nwrite_o)); // R3
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      nwrite_o |-> !bus_oe_o); // R7
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R6
   AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ncs_o && nastrb_o && ndstrb_o)); // R5
endmodule

// File: tb/sim_epp_host_ctrl.sv
module sim_epp_host_ctrl;
   localparam int DW = 8;
   localparam int SU = 2, AS = 3, AH = 2, DMIN = 4, RDD = 6, HD = 2, TO = 20;
   localparam int RLIM = (DMIN > RDD) ? DMIN : RDD;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic [DW-1:0] req_byte = '0, bus_in = '0;
   logic nwait = 1'b0;
   logic req_ready, done, err, ncs, nas, nds, nwr, oe;
   logic [DW-1:0] rd_data, bus_out;

   always #5 clk = ~clk;

   epp_host_ctrl #(.DW(DW), .SETUP_CYC(SU), .ASTRB_CYC(AS), .AHOLD_CYC(AH),
      .DSTRB_MIN_CYC(DMIN), .RD_DLY_CYC(RDD), .HOLD_CYC(HD), .TIMEOUT_CYC(TO),
      .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_byte(req_byte), .req_ready(req_ready), .done_o(done), .err_o(err),
      .rd_data_o(rd_data), .ncs_o(ncs), .nastrb_o(nas), .ndstrb_o(nds),
      .nwrite_o(nwr), .nwait_i(nwait), .bus_out_o(bus_out), .bus_oe_o(oe),
      .bus_in_i(bus_in));

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference of the cycle sequencing
   int m_ph, m_cnt, m_kind;
   logic [DW-1:0] m_byte, m_rd;
   bit m_done, m_err, m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_kind = 0; m_byte = '0; m_rd = '0;
         m_done = 0; m_err = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         int nph;
         bit nd, ne;
         nph = m_ph; nd = 0; ne = 0;
         case (m_ph)
            0: if (req_valid && req_kind != 2'd3) begin
                  nph = 1; m_kind = int'(req_kind); m_byte = req_byte;
               end
            1: if (m_cnt == SU - 1) nph = (m_kind == 0) ? 2 : 4;
            2: if (m_cnt == AS - 1) nph = 3;
            3: if (m_cnt == AH - 1) begin nph = 0; nd = 1; end
            4: begin
                  if (m_s2 && m_cnt >= ((m_kind == 2) ? RLIM : DMIN) - 1) begin
                     nph = 5;
                     if (m_kind == 2) m_rd = bus_in;
                  end else if (m_cnt == TO - 1) begin nph = 0; ne = 1; end
               end
            5: begin
                  if (m_cnt >= HD - 1 && !m_s2) begin nph = 0; nd = 1; end
                  else if (m_cnt == TO - 1) begin nph = 0; ne = 1; end
               end
            default: nph = 0;
         endcase
         m_cnt = (nph != m_ph) ? 0 : ((m_cnt < 1000) ? m_cnt + 1 : m_cnt);
         m_ph = nph; m_done = nd; m_err = ne;
         m_s2 = m_s1; m_s1 = nwait;
      end
   end

   // peripheral model and bus monitors
   int rise_lat = 0, fall_lat = 0, lowc = 0, hic = 0, cyc = 0;
   bit stuck_low = 0, stuck_high = 0;
   int as_w = 0, as_last = 0, as_falls = 0, ds_w = 0, ds_last = 0;
   int nw_rise_at = 0, ds_rise_at = 0;
   logic nds_prev = 1'b1, nas_prev = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         logic e_ncs, e_nas, e_nds, e_nwr, e_oe;
         logic [DW-1:0] e_bus;
         bit rd;
         rd = (m_kind == 2);
         e_ncs = (m_ph == 0); e_nas = (m_ph != 2); e_nds = (m_ph != 4);
         e_nwr = (m_ph == 0) ? 1'b1 : rd;
         e_oe = (m_ph != 0) && !rd;
         e_bus = e_oe ? m_byte : '0;
         checks++;
         if ({ncs, nas, nds, nwr, oe, bus_out, req_ready, done, err, rd_data} !==
             {e_ncs, e_nas, e_nds, e_nwr, e_oe, e_bus, (m_ph == 0), m_done, m_err, m_rd}) begin
            fails++;
            if (nas !== e_nas) $display("FAIL R2 nastrb actual=%0b expected=%0b", nas, e_nas);
            if (nds !== e_nds) $display("FAIL R4 R8 ndstrb actual=%0b expected=%0b", nds, e_nds);
            if ({nwr, oe, bus_out} !== {e_nwr, e_oe, e_bus})
               $display("FAIL R3 dir/bus actual=%0h expected=%0h", {nwr, oe, bus_out}, {e_nwr, e_oe, e_bus});
            if ({req_ready, done} !== {(m_ph == 0), m_done})
               $display("FAIL R5 ready/done actual=%0b expected=%0b", {req_ready, done}, {(m_ph == 0), m_done});
            if (err !== m_err) $display("FAIL R6 err actual=%0b expected=%0b", err, m_err);
            if (rd_data !== m_rd) $display("FAIL R7 rd_data actual=%0h expected=%0h", rd_data, m_rd);
            if (ncs !== e_ncs) $display("FAIL R10 ncs actual=%0b expected=%0b", ncs, e_ncs);
         end
      end
      if (!nas) as_w++;
      else if (!nas_prev) begin as_last = as_w; as_w = 0; end
      if (!nas && nas_prev) as_falls++;
      if (!nds) ds_w++;
      else if (!nds_prev) begin ds_last = ds_w; ds_w = 0; ds_rise_at = cyc; end
      nas_prev = nas; nds_prev = nds;
      if (!nds) begin lowc++; hic = 0; end else begin hic++; lowc = 0; end
      if (!nds && lowc >= rise_lat && !stuck_low) begin
         if (!nwait) nw_rise_at = cyc;
         nwait = 1'b1;
      end else if (nds && hic >= fall_lat && !stuck_high) nwait = 1'b0;
   end

   task automatic run(input int k, input logic [DW-1:0] b, output bit gd, output bit ge);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(k); req_byte = b;
      @(negedge clk);
      req_valid = 1'b0;
      gd = 0; ge = 0;
      for (int i = 0; i < 200 && !gd && !ge; i++) begin
         @(negedge clk);
         if (done) gd = 1;
         if (err) ge = 1;
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      bit gd, ge;
      int falls0;
      repeat (3) @(negedge clk);
      chk("R1 bus idle in reset", {ncs, nas, nds, nwr, oe, req_ready, done, err}, 8'b1111_0100);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bus idle after reset", {ncs, nas, nds, nwr, oe, req_ready}, 6'b111101);

      // R2 address write
      run(0, 8'hA5, gd, ge);
      chk("R2 address write done", {gd, ge}, 2'b10);
      chk("R2 address strobe width", as_last, AS);

      // R3 R4 fast data write: minimum width governs
      rise_lat = 0; fall_lat = 0;
      run(1, 8'h3C, gd, ge);
      chk("R3 data write done", {gd, ge}, 2'b10);
      chk("R4 strobe at least minimum", ds_last >= DMIN, 1);
      chk("R5 wait low at done", nwait, 0);

      // R8 slow peripheral: wait line governs release
      rise_lat = 10;
      run(1, 8'hC3, gd, ge);
      chk("R8 release three cycles after wait rise", ds_rise_at - nw_rise_at, 3);
      chk("R4 slow strobe stretched", ds_last >= 10, 1);

      // R7 reads
      rise_lat = 0; bus_in = 8'h5A;
      run(2, 8'h00, gd, ge);
      chk("R7 read done", {gd, ge}, 2'b10);
      chk("R7 read data", rd_data, 8'h5A);
      chk("R7 read strobe width", ds_last >= RLIM, 1);
      fall_lat = 6; bus_in = 8'h96;
      run(2, 8'h00, gd, ge);
      chk("R7 read data slow release", rd_data, 8'h96);
      chk("R5 wait low at done slow", nwait, 0);

      // R9 requests while busy are ignored
      fall_lat = 0; rise_lat = 10; falls0 = as_falls;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd1; req_byte = 8'h11;
      @(negedge clk);
      req_kind = 2'd0; req_byte = 8'hEE;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      gd = 0;
      for (int i = 0; i < 100 && !gd; i++) begin
         @(negedge clk);
         if (done) gd = 1;
      end
      repeat (6) @(negedge clk);
      chk("R9 busy request ignored", as_falls, falls0);
      rise_lat = 0;

      // R9 reserved kind ignored
      req_valid = 1'b1; req_kind = 2'd3;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R9 reserved kind stays idle", {req_ready, ncs, nds, nas}, 4'b1111);
      end
      req_valid = 1'b0;

      // R6 timeout with wait stuck low
      stuck_low = 1;
      run(2, 8'h00, gd, ge);
      chk("R6 strobe timeout err", {gd, ge}, 2'b01);
      chk("R6 bus idle after abort", {ncs, nds, nwr, oe}, 4'b1110);
      stuck_low = 0;

      // R6 timeout with wait stuck high
      stuck_high = 1;
      run(1, 8'h77, gd, ge);
      chk("R6 hold timeout err", {gd, ge}, 2'b01);
      chk("R6 bus idle after hold abort", {ncs, nds, oe}, 3'b110);
      stuck_high = 0;
      repeat (6) @(negedge clk);

      // R5 back-to-back writes
      fall_lat = 5;
      run(1, 8'h01, gd, ge);
      chk("R5 first of pair", {gd, ge, nwait}, 3'b100);
      run(0, 8'h02, gd, ge);
      chk("R5 second of pair", {gd, ge}, 2'b10);
      repeat (4) @(negedge clk);
      summary();
   end
endmodule